// File: doc/BRIEF.md
# Masked Multi-Vector Interrupt Controller

This block gathers interrupt requests from peripheral logic into a 32-bit pending register. A second 32-bit register holds one enable bit per request. The enabled requests are then routed to four CPU interrupt lines, and each line has its own vector. A peripheral raises a request by pulsing its bit on a set vector. The bit then stays pending until software clears it.

Software reaches both registers over a small register bus. The pending register sits at offset 0 and the enable register at offset 4. A write to the pending register never sets a bit. The written word is ANDed into the current contents, so software acknowledges a request by writing a word with a 0 at that bit position and 1s everywhere else.

Each line has its own mask of request bits. The default masks make some request bits private to a single line and share a group of bits on one line. One bit feeds two lines at once.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the pending register and the enable register read 0, and all four interrupt lines are low.
- R2: A write at offset 4 loads the enable register with the full written word, and a read at offset 4 returns that word.
- R3: A write at offset 0 leaves pending = old pending AND written word. A 0 bit clears that request and a 1 bit keeps it. No write at offset 0 can set a bit.
- R4: A 1 on bit n of `irq_set` sets pending bit n at the next clock edge. The bit stays set after the pulse ends.
- R5: If a set pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R6: A pending bit drives no line while its enable bit is 0. The bit stays pending, and its line rises once the enable bit is written to 1.
- R7: With the default masks, line 0 follows request bit 0 only. Line 1 follows bit 2 only. Line 2 is the OR of bits 2 through 8. Line 3 follows bit 10 only. All other bits (1, 9, 11 to 31) reach no line.
- R8: Lines are registered. A line goes high one clock edge after a mapped bit of (pending AND enable) becomes 1. It goes low one edge after all of its mapped bits are 0.
- R9: A write to the enable register leaves the pending register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_set | input | 32 | Per-bit request set pulses from peripherals |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset: 0 = pending, 4 = enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` (0 for other offsets) |
| irq_line | output | 4 | Registered interrupt lines, one per vector |

## Verification
Single requests are raised one at a time on bits 0, 2, 5, 8 and 10. This separates a private line from the shared line, and it exposes bit 2 driving two lines at once. Bits 1 and 31 are raised together with bit 10. This shows that unmapped bits reach no line but still read back as pending.

A clear word with 1s next to the cleared bit shows that the write is an AND and not a store. A set pulse that lands in the same cycle as a clear of that bit tells set-priority apart from clear-priority. A request raised while its enable bit is 0, and enabled later, tells gating apart from discarding.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned IRQ_W   = 32;
  localparam int unsigned LINE_N  = 4;

  // Default line masks: line 3 <- bit 10, line 2 <- bits 2..8,
  // line 1 <- bit 2, line 0 <- bit 0.
  localparam logic [LINE_N-1:0][IRQ_W-1:0] DEF_LINE_MASK =
    {32'h0000_0400, 32'h0000_01FC, 32'h0000_0004, 32'h0000_0001};

  // Next pending value: optional AND-clear by software, then set pulses on top.
  function automatic logic [IRQ_W-1:0] pend_next(
    input logic [IRQ_W-1:0] cur,
    input logic [IRQ_W-1:0] set_v,
    input logic             clr_stb,
    input logic [IRQ_W-1:0] keep_mask
  );
    logic [IRQ_W-1:0] kept;
    kept = clr_stb ? (cur & keep_mask) : cur;
    return kept | set_v;
  endfunction

  // A line is active when any of its mapped bits is pending and enabled.
  function automatic logic line_hit(
    input logic [IRQ_W-1:0] active,
    input logic [IRQ_W-1:0] mask
  );
    return |(active & mask);
  endfunction

endpackage

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_v,
  input  logic             clr_stb,
  input  logic [IRQ_W-1:0] keep_mask,
  output logic [IRQ_W-1:0] pend_q
);

  logic [IRQ_W-1:0] pend_d;

  always_comb pend_d = pend_next(pend_q, set_v, clr_stb, keep_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // A set pulse always lands, even against a clear in the same cycle.
  p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // No bit appears unless it was pending or pulsed.
  p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~($past(pend_q) | $past(set_v))) == '0));

  // Software clear only removes bits it zeroed.
  p_and_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((pend_q & ~$past(keep_mask) & ~$past(set_v)) == '0));

  // Without a clear, pending bits are kept.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/irqc_en_reg.sv
module irqc_en_reg
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [IRQ_W-1:0] ld_data,
  output logic [IRQ_W-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (ld_stb) en_q <= ld_data;
  end

  p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> (en_q == $past(ld_data)));

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> $stable(en_q));

endmodule

// File: rtl/irqc_line_map.sv
module irqc_line_map
  import irqc_pkg::*;
#(
  parameter int unsigned                    NUM_LINES = LINE_N,
  parameter logic [NUM_LINES-1:0][IRQ_W-1:0] LINE_MASK = DEF_LINE_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_W-1:0]     active,
  output logic [NUM_LINES-1:0] line_q
);

  logic [NUM_LINES-1:0] line_hit_w;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_comb line_hit_w[g] = line_hit(active, LINE_MASK[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[g] <= 1'b0;
      else        line_q[g] <= line_hit_w[g];
    end

    // Line rises one edge after a mapped active bit.
    p_line_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((active & LINE_MASK[g]) != '0) |=> line_q[g]);

    // Line falls one edge after all mapped bits are gone.
    p_line_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((active & LINE_MASK[g]) == '0) |=> !line_q[g]);
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned                    ADDR_W    = 3,
  parameter int unsigned                    PEND_OFS  = 0,
  parameter int unsigned                    EN_OFS    = 4,
  parameter int unsigned                    NUM_LINES = LINE_N,
  parameter logic [NUM_LINES-1:0][IRQ_W-1:0] LINE_MASK = DEF_LINE_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_W-1:0]     irq_set,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [IRQ_W-1:0]     bus_wdata,
  output logic [IRQ_W-1:0]     bus_rdata,
  output logic [NUM_LINES-1:0] irq_line
);

  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

  logic             sel_pend, sel_en;
  logic             pend_clr_stb, en_ld_stb;
  logic [IRQ_W-1:0] pend_w, en_w, active_w;

  always_comb begin
    sel_pend     = (bus_addr == PEND_A);
    sel_en       = (bus_addr == EN_A);
    pend_clr_stb = bus_wr && sel_pend;
    en_ld_stb    = bus_wr && sel_en;
    active_w     = pend_w & en_w;
  end

  irqc_pend_reg i_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_v     (irq_set),
    .clr_stb   (pend_clr_stb),
    .keep_mask (bus_wdata),
    .pend_q    (pend_w)
  );

  irqc_en_reg i_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_stb  (en_ld_stb),
    .ld_data (bus_wdata),
    .en_q    (en_w)
  );

  irqc_line_map #(
    .NUM_LINES (NUM_LINES),
    .LINE_MASK (LINE_MASK)
  ) i_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active_w),
    .line_q (irq_line)
  );

  always_comb begin
    if (sel_pend)    bus_rdata = pend_w;
    else if (sel_en) bus_rdata = en_w;
    else             bus_rdata = '0;
  end

  // An enable write never disturbs pending state.
  p_en_write_keeps_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ld_stb && irq_set == '0) |=> (pend_w == $past(pend_w)));

  // A line is only high if a mapped bit was both pending and enabled.
  p_line_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_line) |-> $past((pend_w & en_w) != '0));

  // Bus decode is exclusive.
  p_decode_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_clr_stb && en_ld_stb));

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_set = '0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [31:0] exp_data;
    logic [3:0]  exp_line;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;  // 125 MHz

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_set   (irq_set),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_line  (irq_line)
  );

  // Monitor: one item per driven cycle, compared at the falling edge after the rising edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.exp_data) begin
        errors++;
        $display("FAIL %s data: actual %h expected %h", it.tag, bus_rdata, it.exp_data);
      end
      checks++;
      if (irq_line !== it.exp_line) begin
        errors++;
        $display("FAIL %s line: actual %b expected %b", it.tag, irq_line, it.exp_line);
      end
    end
  end

  // Driver: apply one cycle of stimulus, record what should be visible after its edge.
  task automatic cyc(input logic [31:0] hw, input logic wr, input logic [2:0] addr,
                     input logic [31:0] wdata, input logic [31:0] exp_data,
                     input logic [3:0] exp_line, input string tag);
    item_t it;
    @(negedge clk); #1;
    irq_set   = hw;
    bus_wr    = wr;
    bus_addr  = addr;
    bus_wdata = wdata;
    it.tag = tag; it.exp_data = exp_data; it.exp_line = exp_line;
    sb.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    cyc('0, 0, 3'd0, '0, 32'h0, 4'b0000, "R1 pend");
    cyc('0, 0, 3'd4, '0, 32'h0, 4'b0000, "R1 en");
    // R2 enable all
    cyc('0, 1, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0000, "R2 en load");
    // R4/R8 bit 0 -> line 0
    cyc(32'h1, 0, 3'd0, '0, 32'h1, 4'b0000, "R4 set bit0");
    cyc('0, 0, 3'd0, '0, 32'h1, 4'b0001, "R8 rise line0 R7");
    cyc('0, 1, 3'd0, 32'hFFFF_FFFE, 32'h0, 4'b0001, "R3 clear bit0");
    cyc('0, 0, 3'd0, '0, 32'h0, 4'b0000, "R8 fall line0");
    // R7 bit 2 drives lines 1 and 2
    cyc(32'h4, 0, 3'd0, '0, 32'h4, 4'b0000, "R4 set bit2");
    cyc('0, 0, 3'd0, '0, 32'h4, 4'b0110, "R7 bit2 two lines");
    cyc(32'h20, 0, 3'd0, '0, 32'h24, 4'b0110, "R4 set bit5");
    cyc('0, 1, 3'd0, 32'hFFFF_FFFB, 32'h20, 4'b0110, "R3 clear bit2 keep bit5");
    cyc('0, 0, 3'd0, '0, 32'h20, 4'b0100, "R7 bit5 shared line");
    // R7 bit 10 and unmapped bits
    cyc(32'h8000_0402, 0, 3'd0, '0, 32'h8000_0422, 4'b0100, "R4 set 10,1,31");
    cyc('0, 0, 3'd0, '0, 32'h8000_0422, 4'b1100, "R7 bit10 line3");
    cyc('0, 1, 3'd0, 32'h8000_0002, 32'h8000_0002, 4'b1100, "R3 keep unmapped");
    cyc('0, 0, 3'd0, '0, 32'h8000_0002, 4'b0000, "R7 unmapped no line");
    // R6 gating, R9 enable write keeps pending
    cyc('0, 1, 3'd4, 32'h1, 32'h1, 4'b0000, "R2 en narrow");
    cyc('0, 0, 3'd0, '0, 32'h8000_0002, 4'b0000, "R9 pend unchanged");
    cyc(32'h100, 0, 3'd0, '0, 32'h8000_0102, 4'b0000, "R4 set bit8");
    cyc('0, 0, 3'd0, '0, 32'h8000_0102, 4'b0000, "R6 disabled no line");
    cyc('0, 1, 3'd4, 32'h100, 32'h100, 4'b0000, "R2 en bit8");
    cyc('0, 0, 3'd4, '0, 32'h100, 4'b0100, "R6 enabled line rises");
    // R5 set wins over clear
    cyc(32'h100, 1, 3'd0, 32'h0, 32'h100, 4'b0100, "R5 set beats clear");
    cyc('0, 1, 3'd0, 32'h0, 32'h0, 4'b0100, "R3 clear all");
    cyc('0, 0, 3'd0, '0, 32'h0, 4'b0000, "R8 fall line2");
    // R3 AND semantics with all-ones word
    cyc(32'h5, 0, 3'd0, '0, 32'h5, 4'b0000, "R4 set 0 and 2");
    cyc('0, 1, 3'd0, 32'hFFFF_FFFF, 32'h5, 4'b0000, "R3 ones keep");
    cyc('0, 0, 3'd0, '0, 32'h5, 4'b0000, "R6 en only bit8");
    @(negedge clk); #1;
    irq_set = '0; bus_wr = 0;
    @(negedge clk); #1;
    finish_run();
  end

endmodule